// File: doc/BRIEF.md
# Per-Frame Pixel Histogram Engine

This block watches a composited RGB pixel stream at the tail of a display pipe and sorts every valid pixel into one of 32 bins. The bin index is taken from the 5 most significant bits of a per-pixel brightness figure. That figure is either the largest of the three colour components or a weighted luma, (77·R + 150·G + 29·B) >> 8. A start-of-frame beat opens a new histogram. An end-of-frame beat freezes the finished counts into a snapshot bank and raises a one-cycle done pulse.

Software-side logic reads the snapshot one bin per address through a registered read port. Because the read port only sees the snapshot, results stay steady while the next frame is being counted. The component width is a parameter (8 or 10 bits are the intended settings), and the shift that keeps 5 bits follows from it. Counters default to 32 bits, which covers a 10240×4320 frame with room to spare. A counter that fills up stays at all-ones.

Top module: `pix_hist32`

## Requirements
- R1: With mode_sel = 0 (max mode), a valid pixel increments bin max(R,G,B) >> (COMP_W − 5).
- R2: With mode_sel = 1 (weighted mode), a valid pixel increments bin ((77·R + 150·G + 29·B) >> 8) >> (COMP_W − 5).
- R3: A bin counter that holds 2^CNT_W − 1 keeps that value when further pixels land in it.
- R4: A valid beat with px_sof = 1 zeroes every working bin and counts that beat's own pixel. A frame of one beat, with sof and eof both set, reports exactly one pixel.
- R5: A valid beat with px_eof = 1, including its own pixel, is copied into the snapshot. frame_done is high for exactly one cycle, two rising edges after that beat is sampled.
- R6: rd_data shows snapshot bin rd_addr one edge after rd_addr is sampled. It keeps showing the previous frame while a new frame is being counted.
- R7: mode_sel is sampled only on a valid start-of-frame beat. Changing it in the middle of a frame does not alter how that frame is binned.
- R8: Beats with px_valid = 0 are ignored, including their colour, px_sof and px_eof: no count, no clear, no snapshot, no done.
- R9: After reset every snapshot bin reads 0 and frame_done is low.
- R10: With 8-bit components, a frame of pure red (255,0,0) in max mode places every pixel in bin 31 and leaves all other bins at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | Pixel beat qualifier |
| px_sof | input | 1 | First pixel of a frame |
| px_eof | input | 1 | Last pixel of a frame |
| px_r | input | COMP_W | Red component |
| px_g | input | COMP_W | Green component |
| px_b | input | COMP_W | Blue component |
| mode_sel | input | 1 | 0 = max of components, 1 = weighted luma |
| rd_addr | input | 5 | Snapshot bin to read |
| rd_data | output | CNT_W | Registered snapshot count |
| frame_done | output | 1 | One-cycle pulse when a snapshot is taken |

## Verification
A wrong bin index, a missed clear or a lost increment stays hidden inside the working counters until the next end-of-frame. It then shows up in the snapshot readout two edges after the closing beat, as a count that is off in one or more bins. A counter that wraps instead of saturating shows up as a small value in a bin that was fed more than 2^CNT_W pixels. For this reason the bench runs a second configuration with 10-bit components and 4-bit counters, where saturation happens within the first frame. Snapshot corruption in the middle of a frame, or a stray done pulse, is visible at once on rd_data or frame_done, and the bench reads the old snapshot while a new frame is in flight.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic {
    HM_MAX    = 1'b0,
    HM_WEIGHT = 1'b1
  } hist_mode_e;

  localparam int LUMA_KR = 77;
  localparam int LUMA_KG = 150;
  localparam int LUMA_KB = 29;
  localparam int LUMA_SH = 8;
endpackage

// File: rtl/hist_bin_calc.sv
module hist_bin_calc
  import hist_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int BIN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [COMP_W-1:0] in_r,
  input  logic [COMP_W-1:0] in_g,
  input  logic [COMP_W-1:0] in_b,
  input  hist_mode_e        mode_req,
  output logic              s_valid,
  output logic              s_sof,
  output logic              s_eof,
  output logic [BIN_W-1:0]  s_bin
);
  localparam int SHIFT = COMP_W - BIN_W;
  localparam int SUM_W = COMP_W + LUMA_SH;

  hist_mode_e        mode_q;
  hist_mode_e        mode_use;
  logic              start;
  logic [COMP_W-1:0] max_rg;
  logic [COMP_W-1:0] max_rgb;
  logic [SUM_W-1:0]  wsum;
  logic [COMP_W-1:0] luma;
  logic [BIN_W-1:0]  bin_max;
  logic [BIN_W-1:0]  bin_wt;
  logic [BIN_W-1:0]  bin_sel;

  always_comb begin
    start    = in_valid && in_sof;
    mode_use = start ? mode_req : mode_q;
    max_rg   = (in_r >= in_g) ? in_r : in_g;
    max_rgb  = (max_rg >= in_b) ? max_rg : in_b;
    wsum     = SUM_W'(LUMA_KR) * SUM_W'(in_r)
             + SUM_W'(LUMA_KG) * SUM_W'(in_g)
             + SUM_W'(LUMA_KB) * SUM_W'(in_b);
    luma     = wsum[SUM_W-1:LUMA_SH];
    bin_max  = max_rgb[COMP_W-1:SHIFT];
    bin_wt   = luma[COMP_W-1:SHIFT];
    bin_sel  = (mode_use == HM_WEIGHT) ? bin_wt : bin_max;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= HM_MAX;
      s_valid <= 1'b0;
      s_sof   <= 1'b0;
      s_eof   <= 1'b0;
      s_bin   <= '0;
    end else begin
      if (start) mode_q <= mode_req;
      s_valid <= in_valid;
      s_sof   <= in_valid && in_sof;
      s_eof   <= in_valid && in_eof;
      s_bin   <= bin_sel;
    end
  end
endmodule

// File: rtl/hist_counter_bank.sv
module hist_counter_bank #(
  parameter int NUM_BINS = 32,
  parameter int BIN_W    = 5,
  parameter int CNT_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      s_valid,
  input  logic                      s_sof,
  input  logic                      s_eof,
  input  logic [BIN_W-1:0]          s_bin,
  output logic [NUM_BINS*CNT_W-1:0] work_flat,
  output logic [NUM_BINS*CNT_W-1:0] snap_flat,
  output logic                      frame_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] snap_q;
    logic             hit;

    always_comb begin
      hit = s_valid && (s_bin == BIN_W'(b));
      if (s_sof)
        cnt_nxt = hit ? CNT_W'(1) : '0;
      else if (hit && (cnt_q != CNT_MAX))
        cnt_nxt = cnt_q + CNT_W'(1);
      else
        cnt_nxt = cnt_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q  <= '0;
        snap_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
        if (s_eof) snap_q <= cnt_nxt;
      end
    end

    assign work_flat[b*CNT_W +: CNT_W] = cnt_q;
    assign snap_flat[b*CNT_W +: CNT_W] = snap_q;
  end

  always_ff @(posedge clk) begin
    if (rst) frame_done <= 1'b0;
    else     frame_done <= s_eof;
  end
endmodule

// File: rtl/hist_readout.sv
module hist_readout #(
  parameter int NUM_BINS = 32,
  parameter int BIN_W    = 5,
  parameter int CNT_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BIN_W-1:0]          rd_addr,
  input  logic [NUM_BINS*CNT_W-1:0] snap_flat,
  output logic [CNT_W-1:0]          rd_data
);
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= snap_flat[rd_addr*CNT_W +: CNT_W];
  end
endmodule

// File: rtl/pix_hist32.sv
module pix_hist32
  import hist_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int BIN_W  = 5,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              px_valid,
  input  logic              px_sof,
  input  logic              px_eof,
  input  logic [COMP_W-1:0] px_r,
  input  logic [COMP_W-1:0] px_g,
  input  logic [COMP_W-1:0] px_b,
  input  logic              mode_sel,
  input  logic [BIN_W-1:0]  rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              frame_done
);
  localparam int NUM_BINS = 1 << BIN_W;

  logic                      st_valid;
  logic                      st_sof;
  logic                      st_eof;
  logic [BIN_W-1:0]          st_bin;
  logic [NUM_BINS*CNT_W-1:0] work_flat;
  logic [NUM_BINS*CNT_W-1:0] snap_flat;
  hist_mode_e                mode_req;

  assign mode_req = hist_mode_e'(mode_sel);

  hist_bin_calc #(.COMP_W(COMP_W), .BIN_W(BIN_W)) u_calc (
    .clk(clk), .rst(rst),
    .in_valid(px_valid), .in_sof(px_sof), .in_eof(px_eof),
    .in_r(px_r), .in_g(px_g), .in_b(px_b), .mode_req(mode_req),
    .s_valid(st_valid), .s_sof(st_sof), .s_eof(st_eof), .s_bin(st_bin)
  );

  hist_counter_bank #(.NUM_BINS(NUM_BINS), .BIN_W(BIN_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst),
    .s_valid(st_valid), .s_sof(st_sof), .s_eof(st_eof), .s_bin(st_bin),
    .work_flat(work_flat), .snap_flat(snap_flat), .frame_done(frame_done)
  );

  hist_readout #(.NUM_BINS(NUM_BINS), .BIN_W(BIN_W), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .snap_flat(snap_flat), .rd_data(rd_data)
  );
endmodule

// File: rtl/pix_hist32_chk.sv
module pix_hist32_chk #(
  parameter int BIN_W = 5,
  parameter int CNT_W = 32
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              px_valid,
  input logic                              px_eof,
  input logic                              frame_done,
  input logic [BIN_W-1:0]                  rd_addr,
  input logic [CNT_W-1:0]                  rd_data,
  input logic                              st_sof,
  input logic [(1<<BIN_W)*CNT_W-1:0]       work_flat
);
  localparam int NUM_BINS = 1 << BIN_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= 2'd0;
    else if (since != 2'd2) since <= since + 2'd1;
  end

  p_done_tracks_eof_r5: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd2) |-> (frame_done == $past(px_valid && px_eof, 2)));

  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((since != 2'd0) && (rd_addr == $past(rd_addr)) && !frame_done) |=> $stable(rd_data));

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_chk
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      ((work_flat[b*CNT_W +: CNT_W] == CNT_MAX) && !st_sof) |=> (work_flat[b*CNT_W +: CNT_W] == CNT_MAX));

    p_sof_clear_r4: assert property (@(posedge clk) disable iff (rst)
      st_sof |=> (work_flat[b*CNT_W +: CNT_W] <= CNT_W'(1)));

    p_step_one_r1: assert property (@(posedge clk) disable iff (rst)
      ((since != 2'd0) && !st_sof) |=>
        ((work_flat[b*CNT_W +: CNT_W] == $past(work_flat[b*CNT_W +: CNT_W])) ||
         (work_flat[b*CNT_W +: CNT_W] == $past(work_flat[b*CNT_W +: CNT_W]) + CNT_W'(1))));
  end
endmodule

bind pix_hist32 pix_hist32_chk #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .px_valid(px_valid), .px_eof(px_eof),
  .frame_done(frame_done), .rd_addr(rd_addr), .rd_data(rd_data),
  .st_sof(st_sof), .work_flat(work_flat)
);

// File: tb/test_pix_hist32.sv
`timescale 1ns/1ps
module test_pix_hist32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v = 1'b0, sof = 1'b0, eof = 1'b0, msel = 1'b0;
  logic [9:0]  r = '0, g = '0, b = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd8;
  logic [3:0]  rd10;
  logic        done8, done10;

  int tests = 0, fails = 0;
  longint wk8[32], wk10[32], sh8[32], sh10[32];
  int cur_mode = 0;
  int eofs = 0, pulses = 0;

  always #4 clk = ~clk;

  pix_hist32 #(.COMP_W(8), .BIN_W(5), .CNT_W(32)) i_pix_hist32 (
    .clk(clk), .rst(rst), .px_valid(v), .px_sof(sof), .px_eof(eof),
    .px_r(r[7:0]), .px_g(g[7:0]), .px_b(b[7:0]), .mode_sel(msel),
    .rd_addr(rd_addr), .rd_data(rd8), .frame_done(done8));

  pix_hist32 #(.COMP_W(10), .BIN_W(5), .CNT_W(4)) i_pix_hist32_w10 (
    .clk(clk), .rst(rst), .px_valid(v), .px_sof(sof), .px_eof(eof),
    .px_r(r), .px_g(g), .px_b(b), .mode_sel(msel),
    .rd_addr(rd_addr), .rd_data(rd10), .frame_done(done10));

  always @(posedge clk) if (!rst && done8) pulses++;

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_bin(input int w, input int mode, input int rr, input int gg, input int bb);
    int m;
    int msk = (1 << w) - 1;
    rr &= msk; gg &= msk; bb &= msk;
    if (mode == 0) begin
      m = rr;
      if (gg > m) m = gg;
      if (bb > m) m = bb;
    end else
      m = (77*rr + 150*gg + 29*bb) >> 8;
    return m >> (w - 5);
  endfunction

  task automatic beat(input int rr, input int gg, input int bb, input bit vv, input bit ss, input bit ee);
    @(negedge clk);
    r = 10'(rr); g = 10'(gg); b = 10'(bb); v = vv; sof = ss; eof = ee;
    if (vv) begin
      if (ss) begin
        for (int k = 0; k < 32; k++) begin wk8[k] = 0; wk10[k] = 0; end
        cur_mode = int'(msel);
      end
      begin
        int i8  = exp_bin(8, cur_mode, rr, gg, bb);
        int i10 = exp_bin(10, cur_mode, rr, gg, bb);
        if (wk8[i8] < 64'hFFFF_FFFF) wk8[i8]++;
        if (wk10[i10] < 15) wk10[i10]++;
      end
      if (ee) begin
        for (int k = 0; k < 32; k++) begin sh8[k] = wk8[k]; sh10[k] = wk10[k]; end
        eofs++;
      end
    end
  endtask

  task automatic close_frame(input string tag);
    @(negedge clk); v = 1'b0; sof = 1'b0; eof = 1'b0;
    chk({tag, " R5 done early"}, done8, 0);
    @(negedge clk);
    chk({tag, " R5 done8"}, done8, 1);
    chk({tag, " R5 done10"}, done10, 1);
    @(negedge clk);
    chk({tag, " R5 done width"}, done8, 0);
  endtask

  task automatic read_all(input string tag);
    v = 1'b0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk); rd_addr = 5'(k);
      @(negedge clk);
      chk({tag, " 8b"}, rd8, sh8[k]);
      chk({tag, " 10b"}, rd10, sh10[k]);
    end
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) begin wk8[k] = 0; wk10[k] = 0; sh8[k] = 0; sh10[k] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R9 done after reset", done8, 0);
    read_all("R9 reset bank");

    // Frame A: max mode, near-exhaustive red sweep; 10-bit copy saturates (R1, R3)
    msel = 1'b0;
    for (int i = 0; i < 1024; i++)
      beat(i, (i*37+5) & 1023, (i*101+9) & 1023, 1'b1, i == 0, i == 1023);
    close_frame("A");
    read_all("R1/R3 max sweep");

    // Frame B: weighted mode with idle gaps (R2)
    msel = 1'b1;
    for (int i = 0; i < 600; i++) begin
      beat((i*53) & 1023, (i*29+300) & 1023, (i*7+11) & 1023, 1'b1, i == 0, i == 599);
      if (i % 17 == 3) beat(0, 0, 0, 1'b0, 1'b0, 1'b0);
    end
    close_frame("B");
    read_all("R2 weighted");

    // Frame C: pure red, mode change mid-frame, ignored beats, mid-frame reads
    msel = 1'b0;
    for (int i = 0; i < 100; i++) beat(255, 0, 0, 1'b1, i == 0, 1'b0);
    msel = 1'b1;                                   // R7: must not apply now
    beat(0, 0, 0, 1'b0, 1'b1, 1'b0);               // R8: invalid sof
    beat(0, 0, 0, 1'b0, 1'b0, 1'b1);               // R8: invalid eof
    @(negedge clk); v = 1'b0; sof = 1'b0; eof = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 no done on invalid eof", done8, 0);
    read_all("R6 old snapshot mid-frame");
    for (int i = 0; i < 100; i++) beat(255, 0, 0, 1'b1, 1'b0, i == 99);
    close_frame("C");
    read_all("R10/R7/R8 pure red");
    chk("R10 bin31", sh8[31], 200);

    // Frame D: single-beat frame, weighted mode latched from msel=1 (R4)
    beat(0, 0, 0, 1'b1, 1'b1, 1'b1);
    close_frame("D");
    read_all("R4 one-pixel frame");
    chk("R4 bin0", sh8[0], 1);

    chk("R5 pulse count", pulses, eofs);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule